// File: doc/BRIEF.md
# Glitch-free clock stop controller

This block takes one input clock and produces four output clocks. Each output is a true/complement pair, and each side of a pair has its own drive-enable. An active-low stop request halts a selected subset of the pairs and later restarts them. The request is asynchronous to the clock. A mask chooses which pairs respond to the request; the other pairs follow the input clock at all times.

The request is synchronized on the falling edge of the input clock, which is the rising edge of the complement. A change is accepted only after it has been seen at the same level on two consecutive such edges. Stoppable pairs then finish their current phase and park in one of two states, chosen by a mode input:

- **Driven park:** true high and driven, complement low and undriven.
- **Floating park:** both sides low and both undriven.

On release, all stoppable pairs restart on the same edge. In floating mode the drivers come back on before the clock restarts.

The park mode and the mask are static controls. They may be changed only while no stop is pending or in force.

Top module: `clkstop_ctrl`

## Requirements
- R1: While reset is low, and directly after it is released, every true output follows the input clock, every complement output is its inverse, and all eight drive-enables are 1.
- R2: A low on the stop request that is seen by only one falling edge of the input clock is ignored. Stoppable pairs keep toggling and keep all drive-enables at 1.
- R3: After the request falls, stoppable pairs keep toggling for at least the next three falling edges of the input clock, and they are parked within five input clock periods.
- R4: Bit i of the mask controls pair i. With bit i at 0, pair i runs freely whatever the request: its complement is the inverse of its true output, and both of its drive-enables are 1.
- R5: With the park mode at 0, a parked pair shows true = 1, complement = 0, true drive-enable = 1 and complement drive-enable = 0.
- R6: With the park mode at 1, a parked pair shows true = 0, complement = 0 and both drive-enables = 0.
- R7: After the request rises, the first true-output edge of every stoppable pair occurs at the same instant, between 2 and 6 input clock periods after the release.
- R8: In park mode 1, after the release is accepted, both drive-enables of each stoppable pair return to 1 while its true output is still 0 and its complement is 1. This happens before the first rising edge of the restarted clock.
- R9: No true output ever shows a high or low phase shorter than half an input clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock that is distributed to all pairs |
| rst_n | input | 1 | Asynchronous active-low reset; all pairs run while it is low |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| park_float | input | 1 | Park mode: 0 = driven true-high, 1 = floating low |
| stop_mask | input | N_OUT | Bit i set makes pair i stoppable |
| clk_p | output | N_OUT | True clock level of each pair |
| clk_n | output | N_OUT | Complement clock level of each pair |
| oe_p | output | N_OUT | Drive-enable of each true side |
| oe_n | output | N_OUT | Drive-enable of each complement side |

## Verification
The gating enable changes on the same input clock edge that moves the output it gates. In driven mode, the halt and the restart fall on a rising edge; in floating mode they fall on a falling edge. Both stop and release are provoked in both park modes. A monitor times every true-output interval and flags any that is shorter than half a period, as well as any zero-width toggle. A second case puts the end of a filtered request and the re-enabling of the drivers in the same cycle: the bench samples the floating-mode pins in the gap between driver release and clock restart, and checks that this gap exists at all.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

  typedef enum logic {
    PARK_HI_DRIVEN = 1'b0,
    PARK_LO_FLOAT  = 1'b1
  } park_e;

  typedef struct packed {
    logic tru;
    logic cmp;
    logic tru_oe;
    logic cmp_oe;
  } pair_t;

endpackage

// File: rtl/clkstop_filter.sv
`timescale 1ns/1ps
module clkstop_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req_n,
  output logic run_req
);
  localparam int SW = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic [SW-1:0] sync_q;
  logic          prev_q;
  logic          acc_q;

  // all sampling on the complement rising edge (true falling edge)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      acc_q  <= 1'b1;
    end else begin
      sync_q[0] <= stop_req_n;
      for (int k = 1; k < SW; k++) sync_q[k] <= sync_q[k-1];
      prev_q <= sync_q[SW-1];
      if (sync_q[SW-1] == prev_q) acc_q <= prev_q;
    end
  end

  assign run_req = acc_q;

  AST_ACCEPT_SETTLES: assert property (@(negedge clk) disable iff (!rst_n)
    (acc_q != $past(acc_q)) |=> $stable(acc_q)); // R2

endmodule

// File: rtl/clkstop_enable.sv
`timescale 1ns/1ps
module clkstop_enable
  import clkstop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_req,
  input  park_e park_mode,
  output logic  run_en,
  output logic  hold
);
  logic run_pos;
  logic run_neg;

  // enable for driven park: changes while clock is high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_pos <= 1'b1;
    else        run_pos <= run_req;
  end

  // enable for floating park: changes while clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run_neg <= 1'b1;
    else        run_neg <= run_req;
  end

  always_comb begin
    run_en = (park_mode == PARK_LO_FLOAT) ? run_neg : run_pos;
    hold   = ~run_req & ~run_en;
  end

  AST_HALT_FOLLOWS_ACCEPT: assert property (@(negedge clk) disable iff (!rst_n)
    $fell(run_req) |=> !run_neg); // R3

  AST_DRIVE_BEFORE_RESTART: assert property (@(negedge clk) disable iff (!rst_n)
    ((park_mode == PARK_LO_FLOAT) && $rose(run_neg)) |-> $past(!hold)); // R8

endmodule

// File: rtl/clkstop_lane.sv
`timescale 1ns/1ps
module clkstop_lane
  import clkstop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run_en,
  input  logic  hold,
  input  logic  stoppable,
  input  park_e park_mode,
  output pair_t pins
);
  always_comb begin
    pins = '{tru: clk, cmp: ~clk, tru_oe: 1'b1, cmp_oe: 1'b1};
    if (stoppable) begin
      if (park_mode == PARK_HI_DRIVEN) begin
        pins.tru    = clk | ~run_en;
        pins.tru_oe = 1'b1;
      end else begin
        pins.tru    = clk & run_en;
        pins.tru_oe = ~hold;
      end
      pins.cmp    = hold ? 1'b0 : ~pins.tru;
      pins.cmp_oe = ~hold;
    end
  end

  AST_PARK_HIGH_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (stoppable && hold && park_mode == PARK_HI_DRIVEN)
      |-> (pins.tru && !pins.cmp && pins.tru_oe && !pins.cmp_oe)); // R5

  AST_PARK_FLOAT_LEVELS: assert property (@(negedge clk) disable iff (!rst_n)
    (stoppable && hold && park_mode == PARK_LO_FLOAT)
      |-> (!pins.tru && !pins.cmp && !pins.tru_oe && !pins.cmp_oe)); // R6

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !stoppable |-> (!pins.tru && pins.cmp && pins.tru_oe && pins.cmp_oe)); // R4

endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl
  import clkstop_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             stop_req_n,
  input  logic             park_float,
  input  logic [N_OUT-1:0] stop_mask,
  output logic [N_OUT-1:0] clk_p,
  output logic [N_OUT-1:0] clk_n,
  output logic [N_OUT-1:0] oe_p,
  output logic [N_OUT-1:0] oe_n
);
  park_e mode;
  logic  run_req;
  logic  run_en;
  logic  hold;
  pair_t pins [N_OUT];

  assign mode = park_e'(park_float);

  clkstop_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filter (
    .clk        (clk_in),
    .rst_n      (rst_n),
    .stop_req_n (stop_req_n),
    .run_req    (run_req)
  );

  clkstop_enable u_enable (
    .clk       (clk_in),
    .rst_n     (rst_n),
    .run_req   (run_req),
    .park_mode (mode),
    .run_en    (run_en),
    .hold      (hold)
  );

  for (genvar i = 0; i < N_OUT; i++) begin : g_lane
    clkstop_lane u_lane (
      .clk       (clk_in),
      .rst_n     (rst_n),
      .run_en    (run_en),
      .hold      (hold),
      .stoppable (stop_mask[i]),
      .park_mode (mode),
      .pins      (pins[i])
    );
    assign clk_p[i] = pins[i].tru;
    assign clk_n[i] = pins[i].cmp;
    assign oe_p[i]  = pins[i].tru_oe;
    assign oe_n[i]  = pins[i].cmp_oe;
  end

  AST_LANES_IN_STEP: assert property (@(posedge clk_in) disable iff (!rst_n)
    (((clk_p & stop_mask) == stop_mask) || ((clk_p & stop_mask) == '0))); // R7

endmodule

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
  localparam int  N      = 4;
  localparam real HALF   = 2.5;
  localparam real PERIOD = 5.0;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         stop_req_n = 1'b1;
  logic         park_float = 1'b0;
  logic [N-1:0] mask = 4'b1011;
  logic [N-1:0] clk_p, clk_n, oe_p, oe_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(HALF) clk = ~clk;

  clkstop_ctrl #(.N_OUT(N), .SYNC_STAGES(2)) u0 (
    .clk_in(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .park_float(park_float),
    .stop_mask(mask), .clk_p(clk_p), .clk_n(clk_n), .oe_p(oe_p), .oe_n(oe_n)
  );

  // scoreboard
  typedef struct {
    string        req;
    logic [N-1:0] p, n, op, on;
  } exp_t;
  exp_t q[$];
  event sb_ev;

  task automatic expect_pins(string req, logic [N-1:0] p, logic [N-1:0] n,
                             logic [N-1:0] op, logic [N-1:0] on);
    exp_t e;
    e.req = req; e.p = p; e.n = n; e.op = op; e.on = on;
    q.push_back(e);
    ->sb_ev;
  endtask

  initial begin
    forever begin
      @(sb_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({clk_p, clk_n, oe_p, oe_n} !== {e.p, e.n, e.op, e.on}) begin
          errors++;
          $display("FAIL %s: got p=%b n=%b oep=%b oen=%b expected p=%b n=%b oep=%b oen=%b",
                   e.req, clk_p, clk_n, oe_p, oe_n, e.p, e.n, e.op, e.on);
        end
      end
    end
  end

  task automatic check_cond(string req, bit ok, real act, real expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, act, expv);
    end
  endtask

  // edge monitor: runts and first edge after release
  real          last_edge [N];
  real          first_edge [N];
  real          t_rel = 0.0;
  bit           watch_en = 0;
  bit           armed = 0;
  int           runts = 0;
  logic [N-1:0] prev_p = '0;

  always @(clk_p) begin
    for (int i = 0; i < N; i++) begin
      if (clk_p[i] !== prev_p[i]) begin
        if (watch_en && ($realtime - last_edge[i]) < HALF - 0.1) runts++;
        last_edge[i] = $realtime;
        if (armed && first_edge[i] < 0.0) first_edge[i] = $realtime;
      end
    end
    prev_p = clk_p;
  end

  task automatic at_high();
    @(posedge clk); #1;
  endtask

  task automatic at_low();
    @(negedge clk); #1;
  endtask

  task automatic arm_release();
    for (int i = 0; i < N; i++) first_edge[i] = -1.0;
    t_rel = $realtime;
    armed = 1;
  endtask

  task automatic check_resume(string req);
    real d;
    bit same;
    repeat (8) @(posedge clk);
    armed = 0;
    same = 1;
    for (int i = 0; i < N; i++)
      if (mask[i] && first_edge[i] != first_edge[0]) same = 0;
    check_cond({req, " together"}, same, first_edge[1], first_edge[0]);
    d = first_edge[0] - t_rel;
    check_cond({req, " latency"}, (d >= 2.0*PERIOD) && (d <= 6.0*PERIOD), d, 4.0*PERIOD);
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin last_edge[i] = 0.0; first_edge[i] = -1.0; end
    // R1 during reset and after
    at_low();
    expect_pins("R1 in reset", 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    repeat (2) at_high();
    rst_n = 1'b1;
    watch_en = 1;
    at_high();
    expect_pins("R1 after reset high", 4'b1111, 4'b0000, 4'b1111, 4'b1111);
    at_low();
    expect_pins("R1 after reset low", 4'b0000, 4'b1111, 4'b1111, 4'b1111);

    // R2: single-sample glitch
    at_high();
    stop_req_n = 1'b0;
    #3;
    stop_req_n = 1'b1;
    repeat (6) begin
      at_low();
      expect_pins("R2 glitch ignored", 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    end

    // R3, R5, R4: stop in driven park mode
    at_high();
    stop_req_n = 1'b0;
    repeat (3) begin
      at_low();
      expect_pins("R3 not yet accepted", 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    end
    repeat (2) at_low();
    expect_pins("R5 parked high (R4 pair2 low)", 4'b1011, 4'b0100, 4'b1111, 4'b0100);
    at_high();
    expect_pins("R5 parked high (R4 pair2 high)", 4'b1111, 4'b0000, 4'b1111, 4'b0100);

    // R7: release in driven mode
    at_high();
    stop_req_n = 1'b1;
    arm_release();
    check_resume("R7 driven");
    at_low();
    expect_pins("R7 driven running", 4'b0000, 4'b1111, 4'b1111, 4'b1111);

    // R6: stop in floating mode
    park_float = 1'b1;
    repeat (2) at_high();
    stop_req_n = 1'b0;
    repeat (6) at_high();
    expect_pins("R6 parked float", 4'b0100, 4'b0000, 4'b0100, 4'b0100);
    at_low();
    expect_pins("R6 parked float low phase", 4'b0000, 4'b0100, 4'b0100, 4'b0100);

    // R8 then R7 in floating mode
    at_high();
    stop_req_n = 1'b1;
    arm_release();
    #18;
    expect_pins("R8 drivers on before restart", 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    check_resume("R7 float");
    at_high();
    expect_pins("R7 float running", 4'b1111, 4'b0000, 4'b1111, 4'b1111);

    // R4: empty mask keeps everything free-running
    mask = 4'b0000;
    at_high();
    stop_req_n = 1'b0;
    repeat (7) at_low();
    expect_pins("R4 no stoppable pairs", 4'b0000, 4'b1111, 4'b1111, 4'b1111);
    at_high();
    expect_pins("R4 no stoppable pairs high", 4'b1111, 4'b0000, 4'b1111, 4'b1111);
    stop_req_n = 1'b1;
    repeat (8) at_high();
    mask = 4'b1011;
    repeat (2) at_high();

    // R9
    check_cond("R9 runt pulses", runts == 0, real'(runts), 0.0);

    finished = 1;
    #1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule